// File: doc/BRIEF.md
# Binary-Seconds Real-Time Counter with Wake Alarm

This block is a memory-mapped real-time counter for a simple synchronous register bus: byte address, write enable, write data, read enable and read data, with reads returned in the same cycle. A programmable prescaler divides the bus clock into a one-second tick. Each tick advances a 62-bit binary seconds counter. Software sets the time by writing a 62-bit holding register and then issuing an upload strobe, which copies the holding value into the counter on that clock edge. A download strobe does the reverse: it copies the live counter into the same holding register, so that both halves can be read as one consistent snapshot.

A 43-bit alarm value is compared with the counter through a 62-bit compare mask. A match raises a wake interrupt. Mode bits choose whether the counter is zeroed or keeps counting after a match. A single control register carries paired write-one-to-act strobes (start/stop, alarm on/off, wake set/clear) together with reset, upload and download. Reading the control register returns the running, alarm-enabled, upload-done, match, wake-pending and updated status bits.

Register offsets: control 0x00, mode 0x04, prescaler 0x08, alarm low 0x0C, alarm high 0x10, compare low 0x14, compare high 0x18, time low 0x20, time high 0x24. Any other address reads as zero.

Top module: `brtc_top`

## Requirements
- R1: After reset, control reads 0, mode reads 0, the prescaler reads 0, compare low reads 0xFFFFFFFF, compare high reads 0x3FFFFFFF and wake_irq is low.
- R2: While running, the counter advances by one every (prescaler + 1) clock cycles. An upload or reset strobe restarts the prescaler phase, so the first advance comes exactly prescaler + 1 cycles after that strobe.
- R3: Control bit 0 written as one sets running, and bit 1 written as one clears it. When both are written together, stop wins. While stopped, the counter and the prescaler phase hold. Control bit 0 reads back as running.
- R4: Writing control bit 5 loads the counter with the holding register (time low at 0x20 = bits 31:0, time high at 0x24 = bits 61:32) on that edge. Control bit 5 then reads 1 until the next control write that does not carry bit 5.
- R5: Writing control bit 6 copies the live counter into the holding register. Control bit 10 (updated) then reads 1 until the next control write that does not carry bit 6.
- R6: While the alarm is enabled, a tick whose next count n satisfies ((n XOR alarm) AND compare) == 0 is a match. A match sets control bit 7. When mode bit 1 is set, it also sets the wake pending bit (control bit 9) and drives wake_irq high.
- R7: When mode bit 2 is set, a match zeroes the counter instead of advancing it. When mode bit 2 is clear, counting continues through the match.
- R8: Control bit 2 enables the alarm and bit 3 disables it; off wins when both are written. Bit 3 and bit 8 each clear wake pending and the match bit, and bit 9 sets wake pending. A clear wins over a set or a match in the same cycle, so a read right after the write already shows wake_irq low.
- R9: Control bit 4 zeroes the counter and the prescaler phase. It takes priority over an upload in the same write.
- R10: Read-back widths are 26 bits for the prescaler, 4 bits for mode, 11 bits for alarm high, and 30 bits for compare high and time high. Unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_re is high |
| wake_irq | output | 1 | Wake interrupt, high while pending |

## Verification
A write takes effect on the clock edge where it is sampled. The read of any register is combinational, so a value changed at one edge can be read in the following cycle. The seconds counter first moves prescaler + 1 edges after an upload or reset strobe, and a match is seen at that same tick edge, with wake_irq high from then on. The bench drives at the falling edge and updates its behavioural model at each rising edge using the same sampled inputs. It compares every read and the interrupt pin at the next falling edge, so each result is checked in the cycle it is due.

// File: rtl/brtc_pkg.sv
package brtc_pkg;
  localparam logic [5:0] OFF_CTRL   = 6'h00;
  localparam logic [5:0] OFF_MODE   = 6'h04;
  localparam logic [5:0] OFF_PRE    = 6'h08;
  localparam logic [5:0] OFF_ALM_LO = 6'h0C;
  localparam logic [5:0] OFF_ALM_HI = 6'h10;
  localparam logic [5:0] OFF_CMP_LO = 6'h14;
  localparam logic [5:0] OFF_CMP_HI = 6'h18;
  localparam logic [5:0] OFF_TIM_LO = 6'h20;
  localparam logic [5:0] OFF_TIM_HI = 6'h24;

  localparam int B_START = 0;
  localparam int B_STOP  = 1;
  localparam int B_AON   = 2;
  localparam int B_AOFF  = 3;
  localparam int B_RST   = 4;
  localparam int B_UPL   = 5;
  localparam int B_DOWN  = 6;
  localparam int B_MATCH = 7;
  localparam int B_WCLR  = 8;
  localparam int B_WSET  = 9;
  localparam int B_UPD   = 10;

  localparam int M_CAL  = 0;
  localparam int M_WEN  = 1;
  localparam int M_WRST = 2;
  localparam int M_WCON = 3;
endpackage

// File: rtl/brtc_prescale.sv
module brtc_prescale #(
  parameter int PRE_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] period,
  output logic             tick
);
  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick = run && !restart && (cnt_q >= period);

  always_comb begin
    cnt_en = restart || run;
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/brtc_counter.sv
module brtc_counter #(
  parameter int CNT_W = 62,
  parameter int ALM_W = 43
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic             alarm_en,
  input  logic [ALM_W-1:0] alarm,
  input  logic [CNT_W-1:0] mask,
  input  logic             wake_reset,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam int PAD_W = CNT_W - ALM_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, alm_ext;
  logic             cnt_en;

  assign alm_ext = {{PAD_W{1'b0}}, alarm};
  assign cnt_inc = cnt_q + ONE;
  assign hit     = tick && alarm_en && !load && !clear &&
                   (((cnt_inc ^ alm_ext) & mask) == '0);
  assign count   = cnt_q;

  always_comb begin
    cnt_en = clear || load || tick;
    if (clear)                   cnt_d = '0;
    else if (load)               cnt_d = load_val;
    else if (hit && wake_reset)  cnt_d = '0;
    else                         cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/brtc_regfile.sv
module brtc_regfile
  import brtc_pkg::*;
#(
  parameter int CNT_W = 62,
  parameter int ALM_W = 43,
  parameter int PRE_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_re,
  output logic [31:0]      bus_rdata,
  input  logic [CNT_W-1:0] count,
  input  logic             hit,
  output logic             run,
  output logic             restart,
  output logic             load,
  output logic             clear,
  output logic [CNT_W-1:0] load_val,
  output logic             alarm_en,
  output logic [ALM_W-1:0] alarm,
  output logic [CNT_W-1:0] mask,
  output logic             wake_reset,
  output logic [PRE_W-1:0] period,
  output logic             wake_irq
);
  localparam int CHI_W = CNT_W - 32;
  localparam int AHI_W = ALM_W - 32;

  logic             run_q, run_d;
  logic             aen_q, aen_d;
  logic             pend_q, pend_d;
  logic             match_q, match_d;
  logic             upd_q, upd_d;
  logic             upl_q, upl_d;
  logic [3:0]       mode_q;
  logic [PRE_W-1:0] pre_q;
  logic [ALM_W-1:0] alm_q, alm_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] hold_q, hold_d;

  logic ctrl_wr, mode_wr, pre_wr, alm_wr, cmp_wr, hold_wr;
  logic s_start, s_stop, s_aon, s_aoff, s_rst, s_upl, s_down, s_wclr, s_wset;

  always_comb begin
    ctrl_wr = bus_we && (bus_addr == OFF_CTRL);
    mode_wr = bus_we && (bus_addr == OFF_MODE);
    pre_wr  = bus_we && (bus_addr == OFF_PRE);
    alm_wr  = bus_we && ((bus_addr == OFF_ALM_LO) || (bus_addr == OFF_ALM_HI));
    cmp_wr  = bus_we && ((bus_addr == OFF_CMP_LO) || (bus_addr == OFF_CMP_HI));
    s_start = ctrl_wr && bus_wdata[B_START];
    s_stop  = ctrl_wr && bus_wdata[B_STOP];
    s_aon   = ctrl_wr && bus_wdata[B_AON];
    s_aoff  = ctrl_wr && bus_wdata[B_AOFF];
    s_rst   = ctrl_wr && bus_wdata[B_RST];
    s_upl   = ctrl_wr && bus_wdata[B_UPL];
    s_down  = ctrl_wr && bus_wdata[B_DOWN];
    s_wclr  = ctrl_wr && bus_wdata[B_WCLR];
    s_wset  = ctrl_wr && bus_wdata[B_WSET];
    hold_wr = s_down || (bus_we && ((bus_addr == OFF_TIM_LO) || (bus_addr == OFF_TIM_HI)));
  end

  // next-state for control status
  always_comb begin
    run_d = run_q;
    if (s_stop)       run_d = 1'b0;
    else if (s_start) run_d = 1'b1;

    aen_d = aen_q;
    if (s_aoff)      aen_d = 1'b0;
    else if (s_aon)  aen_d = 1'b1;

    pend_d = pend_q;
    if ((hit && mode_q[M_WEN]) || s_wset) pend_d = 1'b1;
    if (s_wclr || s_aoff)                 pend_d = 1'b0;

    match_d = match_q;
    if (hit)              match_d = 1'b1;
    if (s_wclr || s_aoff) match_d = 1'b0;

    upd_d = ctrl_wr ? s_down : upd_q;
    upl_d = ctrl_wr ? s_upl  : upl_q;
  end

  // next-state for wide data registers
  always_comb begin
    alm_d = alm_q;
    if (bus_addr == OFF_ALM_LO) alm_d[31:0]      = bus_wdata;
    else                        alm_d[ALM_W-1:32] = bus_wdata[AHI_W-1:0];

    cmp_d = cmp_q;
    if (bus_addr == OFF_CMP_LO) cmp_d[31:0]      = bus_wdata;
    else                        cmp_d[CNT_W-1:32] = bus_wdata[CHI_W-1:0];

    hold_d = hold_q;
    if (s_down)                      hold_d = count;
    else if (bus_addr == OFF_TIM_LO) hold_d[31:0] = bus_wdata;
    else                             hold_d[CNT_W-1:32] = bus_wdata[CHI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      aen_q   <= 1'b0;
      pend_q  <= 1'b0;
      match_q <= 1'b0;
      upd_q   <= 1'b0;
      upl_q   <= 1'b0;
    end else begin
      run_q   <= run_d;
      aen_q   <= aen_d;
      pend_q  <= pend_d;
      match_q <= match_d;
      upd_q   <= upd_d;
      upl_q   <= upl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pre_q  <= '0;
      alm_q  <= '0;
      cmp_q  <= '1;
      hold_q <= '0;
    end else begin
      if (mode_wr) mode_q <= bus_wdata[3:0];
      if (pre_wr)  pre_q  <= bus_wdata[PRE_W-1:0];
      if (alm_wr)  alm_q  <= alm_d;
      if (cmp_wr)  cmp_q  <= cmp_d;
      if (hold_wr) hold_q <= hold_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        OFF_CTRL: begin
          bus_rdata[B_START] = run_q;
          bus_rdata[B_AON]   = aen_q;
          bus_rdata[B_UPL]   = upl_q;
          bus_rdata[B_MATCH] = match_q;
          bus_rdata[B_WSET]  = pend_q;
          bus_rdata[B_UPD]   = upd_q;
        end
        OFF_MODE:   bus_rdata[3:0]       = mode_q;
        OFF_PRE:    bus_rdata[PRE_W-1:0] = pre_q;
        OFF_ALM_LO: bus_rdata            = alm_q[31:0];
        OFF_ALM_HI: bus_rdata[AHI_W-1:0] = alm_q[ALM_W-1:32];
        OFF_CMP_LO: bus_rdata            = cmp_q[31:0];
        OFF_CMP_HI: bus_rdata[CHI_W-1:0] = cmp_q[CNT_W-1:32];
        OFF_TIM_LO: bus_rdata            = hold_q[31:0];
        OFF_TIM_HI: bus_rdata[CHI_W-1:0] = hold_q[CNT_W-1:32];
        default:    bus_rdata            = '0;
      endcase
    end
  end

  assign run        = run_q;
  assign restart    = s_rst || s_upl;
  assign load       = s_upl;
  assign clear      = s_rst;
  assign load_val   = hold_q;
  assign alarm_en   = aen_q;
  assign alarm      = alm_q;
  assign mask       = cmp_q;
  assign wake_reset = mode_q[M_WRST];
  assign period     = pre_q;
  assign wake_irq   = pend_q;
endmodule

// File: rtl/brtc_top.sv
module brtc_top #(
  parameter int CNT_W = 62,
  parameter int ALM_W = 43,
  parameter int PRE_W = 26
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  input  logic        bus_re,
  output logic [31:0] bus_rdata,
  output logic        wake_irq
);
  logic [1:0]       rs_q;
  logic             rst_i;
  logic             run_w, restart_w, load_w, clear_w, aen_w, wrst_w, tick_w, hit_w;
  logic [CNT_W-1:0] count_w, load_val_w, mask_w;
  logic [ALM_W-1:0] alarm_w;
  logic [PRE_W-1:0] period_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  brtc_regfile #(.CNT_W(CNT_W), .ALM_W(ALM_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_i),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_re(bus_re), .bus_rdata(bus_rdata),
    .count(count_w), .hit(hit_w),
    .run(run_w), .restart(restart_w), .load(load_w), .clear(clear_w),
    .load_val(load_val_w), .alarm_en(aen_w), .alarm(alarm_w), .mask(mask_w),
    .wake_reset(wrst_w), .period(period_w), .wake_irq(wake_irq)
  );

  brtc_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_i), .run(run_w), .restart(restart_w),
    .period(period_w), .tick(tick_w)
  );

  brtc_counter #(.CNT_W(CNT_W), .ALM_W(ALM_W)) u_cnt (
    .clk(clk), .rst_n(rst_i), .tick(tick_w), .load(load_w), .load_val(load_val_w),
    .clear(clear_w), .alarm_en(aen_w), .alarm(alarm_w), .mask(mask_w),
    .wake_reset(wrst_w), .count(count_w), .hit(hit_w)
  );
endmodule

// File: rtl/brtc_chk.sv
module brtc_chk #(
  parameter int CNT_W = 62
) (
  input logic             clk,
  input logic             rst_i,
  input logic             ctrl_wr,
  input logic             w_stop,
  input logic             w_aoff,
  input logic             w_rst,
  input logic             w_upl,
  input logic             w_wclr,
  input logic             w_wset,
  input logic             run,
  input logic             hit,
  input logic             wake_irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] hold
);
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_i)
    (ctrl_wr && w_stop) |=> !run);                                        // R3
  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_i)
    (!run && !ctrl_wr) |=> $stable(count));                               // R3
  AST_UPLOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_i)
    (ctrl_wr && w_upl && !w_rst) |=> (count == $past(hold)));             // R4
  AST_RESET_ZEROES: assert property (@(posedge clk) disable iff (!rst_i)
    (ctrl_wr && w_rst) |=> (count == '0));                                // R9
  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_i)
    (ctrl_wr && (w_aoff || w_wclr)) |=> !wake_irq);                       // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(wake_irq) |-> $past(hit || (ctrl_wr && w_wset)));               // R6
endmodule

bind brtc_top brtc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_i(rst_i),
  .ctrl_wr(bus_we && (bus_addr == 6'h00)),
  .w_stop(bus_wdata[1]), .w_aoff(bus_wdata[3]), .w_rst(bus_wdata[4]),
  .w_upl(bus_wdata[5]), .w_wclr(bus_wdata[8]), .w_wset(bus_wdata[9]),
  .run(run_w), .hit(hit_w), .wake_irq(wake_irq),
  .count(count_w), .hold(load_val_w)
);

// File: tb/tb_brtc_top.sv
`timescale 1ns/1ps
module tb_brtc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        wake_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  brtc_top dut (.*);

  // behavioural reference model
  logic [1:0]  m_rs;
  bit          m_run, m_aen, m_pend, m_match, m_upd, m_upl;
  logic [3:0]  m_mode;
  logic [25:0] m_pre, m_pcnt;
  logic [42:0] m_alm;
  logic [61:0] m_cmp, m_hold, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_rs = 2'b00;
    else begin
      if (!m_rs[1]) begin
        m_run = 0; m_aen = 0; m_pend = 0; m_match = 0; m_upd = 0; m_upl = 0;
        m_mode = 0; m_pre = 0; m_pcnt = 0; m_alm = 0; m_cmp = '1; m_hold = 0; m_cnt = 0;
      end else begin
        bit cw, tk, ht;
        logic [61:0] nx, old_cnt, old_hold;
        cw = bus_we && bus_addr == 6'h00;
        old_cnt = m_cnt; old_hold = m_hold;
        tk = m_run && (m_pcnt >= m_pre) && !(cw && (bus_wdata[4] || bus_wdata[5]));
        nx = m_cnt + 62'd1;
        ht = tk && m_aen && (((nx ^ {19'd0, m_alm}) & m_cmp) == 62'd0);
        if (cw && bus_wdata[4])      m_cnt = 0;
        else if (cw && bus_wdata[5]) m_cnt = old_hold;
        else if (tk)                 m_cnt = (ht && m_mode[2]) ? 62'd0 : nx;
        if (cw && (bus_wdata[4] || bus_wdata[5])) m_pcnt = 0;
        else if (m_run)              m_pcnt = tk ? 26'd0 : m_pcnt + 26'd1;
        if (ht) m_match = 1;
        if (ht && m_mode[1]) m_pend = 1;
        if (cw) begin
          if (bus_wdata[9]) m_pend = 1;
          if (bus_wdata[8] || bus_wdata[3]) begin m_pend = 0; m_match = 0; end
          if (bus_wdata[1]) m_run = 0; else if (bus_wdata[0]) m_run = 1;
          if (bus_wdata[3]) m_aen = 0; else if (bus_wdata[2]) m_aen = 1;
          m_upd = bus_wdata[6];
          m_upl = bus_wdata[5];
          if (bus_wdata[6]) m_hold = old_cnt;
        end
        if (bus_we) case (bus_addr)
          6'h04: m_mode = bus_wdata[3:0];
          6'h08: m_pre = bus_wdata[25:0];
          6'h0C: m_alm[31:0] = bus_wdata;
          6'h10: m_alm[42:32] = bus_wdata[10:0];
          6'h14: m_cmp[31:0] = bus_wdata;
          6'h18: m_cmp[61:32] = bus_wdata[29:0];
          6'h20: m_hold[31:0] = bus_wdata;
          6'h24: m_hold[61:32] = bus_wdata[29:0];
          default: ;
        endcase
      end
      m_rs = {m_rs[0], 1'b1};
    end
  end

  function automatic logic [31:0] mread(input logic [5:0] a);
    case (a)
      6'h00: return {21'd0, m_upd, m_pend, 1'b0, m_match, 1'b0, m_upl, 2'b0, m_aen, 1'b0, m_run};
      6'h04: return {28'd0, m_mode};
      6'h08: return {6'd0, m_pre};
      6'h0C: return m_alm[31:0];
      6'h10: return {21'd0, m_alm[42:32]};
      6'h14: return m_cmp[31:0];
      6'h18: return {2'd0, m_cmp[61:32]};
      6'h20: return m_hold[31:0];
      6'h24: return {2'd0, m_hold[61:32]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // interrupt pin against model every cycle (R6, R8)
  always @(negedge clk) if (rst_n && m_rs[1] && !done)
    chk("R8 wake_irq pin", {31'd0, wake_irq}, {31'd0, m_pend});

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    #1 v = bus_rdata;
    chk(tag, v, mread(a));
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3); rst_n = 1'b1; idle(4);
    // R1 reset state
    rd("R1 ctrl", 6'h00, v);   chk("R1 ctrl const", v, 32'h0);
    rd("R1 mode", 6'h04, v);   chk("R1 mode const", v, 32'h0);
    rd("R1 pre", 6'h08, v);    chk("R1 pre const", v, 32'h0);
    rd("R1 cmp lo", 6'h14, v); chk("R1 cmp lo const", v, 32'hFFFF_FFFF);
    rd("R1 cmp hi", 6'h18, v); chk("R1 cmp hi const", v, 32'h3FFF_FFFF);
    chk("R1 irq", {31'd0, wake_irq}, 32'd0);

    // R4 upload and start, R2 period 4
    wr(6'h08, 32'd3);
    wr(6'h20, 32'd100); wr(6'h24, 32'd0);
    wr(6'h00, 32'h21);
    wr(6'h00, 32'h40);
    rd("R5 time lo", 6'h20, v); chk("R4 uploaded value", v, 32'd100);
    rd("R5 ctrl updated", 6'h00, v); chk("R5 updated bit", v & 32'h400, 32'h400);
    for (int k = 0; k < 6; k++) begin
      idle(k + 3);
      wr(6'h00, 32'h40);
      rd("R2 time lo", 6'h20, v);
    end
    wr(6'h00, 32'h0);
    rd("R5 updated clears", 6'h00, v); chk("R5 updated cleared", v & 32'h420, 32'h0);
    // R2 prescaler zero: one per cycle
    wr(6'h08, 32'd0); idle(7); wr(6'h00, 32'h40); rd("R2 pre0 time", 6'h20, v);

    // R3 stop / stop wins
    wr(6'h08, 32'd2);
    wr(6'h00, 32'h2); wr(6'h00, 32'h40); rd("R3 stopped a", 6'h20, v);
    idle(12); wr(6'h00, 32'h40); rd("R3 stopped b", 6'h20, v);
    wr(6'h00, 32'h3); rd("R3 stop wins", 6'h00, v); chk("R3 run bit", v & 32'h1, 32'h0);
    wr(6'h00, 32'h1); idle(9); wr(6'h00, 32'h40); rd("R3 resumed", 6'h20, v);

    // R6 alarm match with continue
    wr(6'h04, 32'hA); wr(6'h08, 32'd3);
    wr(6'h20, 32'd200); wr(6'h24, 32'd0);
    wr(6'h0C, 32'd205); wr(6'h10, 32'd0);
    wr(6'h00, 32'h25);
    idle(40);
    chk("R6 irq fired", {31'd0, wake_irq}, 32'd1);
    rd("R6 ctrl match", 6'h00, v); chk("R6 match+pend", v & 32'h284, 32'h284);
    wr(6'h00, 32'h40); rd("R7 continued", 6'h20, v);
    // R8 alarm off clears; set then clear wins
    wr(6'h00, 32'h8); rd("R8 after off", 6'h00, v);
    chk("R8 irq low", {31'd0, wake_irq}, 32'd0);
    wr(6'h00, 32'h200); rd("R8 wake set", 6'h00, v); chk("R8 set pend", v & 32'h200, 32'h200);
    wr(6'h00, 32'h300); rd("R8 clear wins", 6'h00, v); chk("R8 pend clr", v & 32'h200, 32'h0);

    // R7 wake-reset under a 4-bit compare mask
    wr(6'h04, 32'h6);
    wr(6'h14, 32'hF); wr(6'h18, 32'h0);
    wr(6'h0C, 32'd3);
    wr(6'h20, 32'd0); wr(6'h00, 32'h25);
    idle(60);
    wr(6'h00, 32'h40); rd("R7 wrapped", 6'h20, v);
    chk("R7 below alarm", {31'd0, v < 32'd4}, 32'd1);
    wr(6'h00, 32'h8);

    // R9 reset strobe beats upload
    wr(6'h20, 32'd77); wr(6'h00, 32'h30);
    wr(6'h00, 32'h40); rd("R9 zeroed", 6'h20, v); chk("R9 zero", v, 32'd0);

    // R10 widths
    wr(6'h00, 32'h2);
    wr(6'h08, 32'hFFFF_FFFF); rd("R10 pre", 6'h08, v);  chk("R10 pre w", v, 32'h03FF_FFFF);
    wr(6'h10, 32'hFFFF_FFFF); rd("R10 alm hi", 6'h10, v); chk("R10 alm w", v, 32'h7FF);
    wr(6'h24, 32'hFFFF_FFFF); rd("R10 tim hi", 6'h24, v); chk("R10 tim w", v, 32'h3FFF_FFFF);
    wr(6'h18, 32'hFFFF_FFFF); rd("R10 cmp hi", 6'h18, v); chk("R10 cmp w", v, 32'h3FFF_FFFF);
    wr(6'h04, 32'hFFFF_FFFF); rd("R10 mode", 6'h04, v);  chk("R10 mode w", v, 32'hF);
    rd("R10 unmapped", 6'h30, v);

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule